// File: doc/BRIEF.md
# Secure Seconds Counter with Alarm

This block keeps wall-clock time as a free-running count of 32768 Hz ticks, split into a whole-seconds word and a sub-second fraction word. A single-cycle `tick_i` strobe, one per period of the slow reference, advances the fraction. When the fraction carries, the seconds word steps in the same cycle. A seconds-only alarm compare raises a sticky flag and, when enabled, an interrupt line.

The counter is built for a tamper-aware environment. It halts when its enable is clear, when the not-valid flag is set, when the failure input is high, or when it has overflowed. It stays halted until software removes the cause. Two lock bits, one soft and one hard, protect the time base from being rewritten. Both can only be set, and only reset clears them. The slow-domain write synchronizer and the tamper state machine are outside the block. They appear only as the `fail_i` and `nv_set_i` inputs.

Software reaches the block through a simple register port. A write takes effect at the clock edge that samples `wr_en_i`. A read is combinational from `addr_i`. The word addresses are: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt enable. Any other address reads zero.

Top module: `secure_rtc`

## Requirements
- R1: While running, each `tick_i` increments the 15-bit fraction (address 1). When the fraction steps from 0x7FFF to 0, the 32-bit seconds word (address 0) increments on the same edge.
- R2: Counting halts in any of four cases: control bit 3 (enable) is clear; status bit 1 (not-valid) is set; `fail_i` is high; or status bit 2 (overflow) is set. Status bit 0 mirrors `fail_i`. A `nv_set_i` pulse sets status bit 1, and writing 1 to status bit 1 clears it.
- R3: A counting step out of seconds 0xFFFFFFFF with fraction 0x7FFF does three things: it wraps both words to 0, sets status bit 2, and stops counting. Counting resumes only after software writes 1 to status bit 2.
- R4: Writing the seconds word leaves the fraction unchanged. Writing the fraction leaves the seconds unchanged.
- R5: Setting control bit 17 (soft lock) or control bit 18 (hard lock) blocks writes to seconds, fraction and control bit 3. Both lock bits can only be set, never cleared by a write, and only reset clears them.
- R6: Status bit 4 (alarm flag) is set on the counting step that makes the seconds equal the alarm word (address 2). It is not set again while the two stay equal, and writing 1 to bit 4 clears it. Writing the seconds to the alarm value does not set the flag.
- R7: `irq_o` is high exactly when status bit 4 and interrupt-enable bit 4 (address 6) are both set.
- R8: The alarm fraction (address 3) always reads zero and ignores writes. The alarm resets to 0xFFFFFFFF, the "unset" value. That value still matches during the last second before wrap-around.
- R9: After reset, seconds, fraction, control, status and interrupt enable read zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 32768 Hz period |
| fail_i | input | 1 | Failure state from the tamper monitor; halts counting |
| nv_set_i | input | 1 | Pulse that sets the not-valid flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Alarm interrupt |

## Verification
A register write is visible on `rdata_o` from the first falling edge after the rising edge that sampled it. A tick has the same latency: fraction, seconds, overflow and alarm flag all change on the edge that samples `tick_i`. `irq_o` follows the alarm flag with no added register. The bench therefore drives every stimulus at a falling edge and holds it across exactly one rising edge. It reads back combinationally at the next falling edge, so each check lands one edge after its cause. Halt conditions are checked by issuing ticks and confirming that the fraction has not moved.

// File: rtl/secure_rtc_pkg.sv
// Package: register word addresses and bit positions shared by the
// secure seconds counter, its checker and its bench.
package secure_rtc_pkg;

    typedef enum logic [2:0] {
        RA_SEC  = 3'd0,
        RA_FRAC = 3'd1,
        RA_ALM  = 3'd2,
        RA_ALMF = 3'd3,
        RA_CTRL = 3'd4,
        RA_STAT = 3'd5,
        RA_IEN  = 3'd6
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 3;
    localparam int CTRL_SOFT_BIT = 17;
    localparam int CTRL_HARD_BIT = 18;

    localparam int STAT_FAIL_BIT = 0;
    localparam int STAT_NV_BIT   = 1;
    localparam int STAT_OVF_BIT  = 2;
    localparam int STAT_ALM_BIT  = 4;

    localparam int IEN_ALM_BIT   = 4;

endpackage

// File: rtl/secure_rtc_counter.sv
// Module: seconds and fraction time base.
// The fraction advances on every run_i cycle. A carry out of the fraction
// steps the seconds word in the same cycle. A register write to a word has
// priority over counting for that word only. Assumes run_i is already
// gated by every stop condition.
module secure_rtc_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_sec_i,
    input  logic              wr_frac_i,
    input  logic [SEC_W-1:0]  sec_wdata_i,
    input  logic [FRAC_W-1:0] frac_wdata_i,
    output logic [SEC_W-1:0]  sec_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              step_o,
    output logic              wrap_o
);
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
    localparam logic [SEC_W-1:0]  SEC_MAX  = '1;

    logic [SEC_W-1:0]  sec_q;
    logic [FRAC_W-1:0] frac_q;
    logic              carry;

    // Detect fraction carry, counting step of seconds, and full wrap.
    always_comb begin
        carry  = run_i && (frac_q == FRAC_MAX);
        step_o = carry && !wr_sec_i;
        wrap_o = carry && (sec_q == SEC_MAX);
    end

    // Fraction register: write wins, otherwise count.
    always_ff @(posedge clk) begin
        if (!rst_n)         frac_q <= '0;
        else if (wr_frac_i) frac_q <= frac_wdata_i;
        else if (run_i)     frac_q <= frac_q + 1'b1;
    end

    // Seconds register: write wins, otherwise step on fraction carry.
    always_ff @(posedge clk) begin
        if (!rst_n)        sec_q <= '0;
        else if (wr_sec_i) sec_q <= sec_wdata_i;
        else if (carry)    sec_q <= sec_q + 1'b1;
    end

    assign sec_o  = sec_q;
    assign frac_o = frac_q;

endmodule

// File: rtl/secure_rtc_alarm.sv
// Module: seconds alarm compare and sticky alarm flag.
// The flag is raised only on a counting step whose new seconds value
// equals the alarm word, so a lasting equality raises it once. A write to
// the alarm word in the same cycle suppresses the compare. Setting has
// priority over a clear in the same cycle.
module secure_rtc_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic             wr_alm_i,
    input  logic [SEC_W-1:0] alm_wdata_i,
    input  logic             clr_i,
    output logic [SEC_W-1:0] alm_o,
    output logic             flag_o
);
    logic [SEC_W-1:0] alm_q;
    logic             flag_q;
    logic             hit;

    // Compare the seconds value the step is about to produce.
    always_comb begin
        hit = step_i && !wr_alm_i && ((sec_i + 1'b1) == alm_q);
    end

    // Alarm word: resets to the all-ones "unset" value.
    always_ff @(posedge clk) begin
        if (!rst_n)        alm_q <= '1;
        else if (wr_alm_i) alm_q <= alm_wdata_i;
    end

    // Sticky flag: set on hit, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign alm_o  = alm_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/secure_rtc_regs.sv
// Module: register decode, control/status/enable storage, stop logic and
// read multiplexer.
// Lock bits can only be set. While either lock is set, writes to the time
// words and to the enable bit are dropped. Status flags are write-one-to-clear,
// and a hardware set wins over a same-cycle clear. Assumes DATA_W covers
// the highest control bit.
module secure_rtc_regs
    import secure_rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fail_i,
    input  logic              nv_set_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wrap_i,
    input  logic              alm_flag_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [SEC_W-1:0]  alm_i,
    output logic              run_o,
    output logic              wr_sec_o,
    output logic              wr_frac_o,
    output logic              wr_alm_o,
    output logic              clr_alm_o,
    output logic              ien_o,
    output logic              lock_soft_o,
    output logic              lock_hard_o,
    output logic              ovf_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic en_q, soft_q, hard_q, nv_q, ovf_q, ien_q;
    logic locked;
    logic wr_ctrl, wr_stat, wr_ien;
    logic unused_wdata;

    // Address decode and lock gating of the time-base writes.
    always_comb begin
        locked    = soft_q || hard_q;
        wr_ctrl   = wr_en_i && (addr_i == RA_CTRL);
        wr_stat   = wr_en_i && (addr_i == RA_STAT);
        wr_ien    = wr_en_i && (addr_i == RA_IEN);
        wr_sec_o  = wr_en_i && (addr_i == RA_SEC)  && !locked;
        wr_frac_o = wr_en_i && (addr_i == RA_FRAC) && !locked;
        wr_alm_o  = wr_en_i && (addr_i == RA_ALM);
        clr_alm_o = wr_stat && wdata_i[STAT_ALM_BIT];
        run_o     = tick_i && en_q && !nv_q && !ovf_q && !fail_i;
    end

    // Control: set-only locks, enable frozen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            soft_q <= 1'b0;
            hard_q <= 1'b0;
        end else if (wr_ctrl) begin
            soft_q <= soft_q || wdata_i[CTRL_SOFT_BIT];
            hard_q <= hard_q || wdata_i[CTRL_HARD_BIT];
            if (!locked) en_q <= wdata_i[CTRL_EN_BIT];
        end
    end

    // Not-valid flag: set by pulse, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                               nv_q <= 1'b0;
        else if (nv_set_i)                        nv_q <= 1'b1;
        else if (wr_stat && wdata_i[STAT_NV_BIT]) nv_q <= 1'b0;
    end

    // Overflow flag: set on wrap, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ovf_q <= 1'b0;
        else if (wrap_i)                           ovf_q <= 1'b1;
        else if (wr_stat && wdata_i[STAT_OVF_BIT]) ovf_q <= 1'b0;
    end

    // Interrupt enable for the alarm.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (wr_ien) ien_q <= wdata_i[IEN_ALM_BIT];
    end

    // Read multiplexer; alarm fraction and unmapped addresses read zero.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_SEC:  rdata_o = DATA_W'(sec_i);
            RA_FRAC: rdata_o = DATA_W'(frac_i);
            RA_ALM:  rdata_o = DATA_W'(alm_i);
            RA_CTRL: begin
                rdata_o[CTRL_EN_BIT]   = en_q;
                rdata_o[CTRL_SOFT_BIT] = soft_q;
                rdata_o[CTRL_HARD_BIT] = hard_q;
            end
            RA_STAT: begin
                rdata_o[STAT_FAIL_BIT] = fail_i;
                rdata_o[STAT_NV_BIT]   = nv_q;
                rdata_o[STAT_OVF_BIT]  = ovf_q;
                rdata_o[STAT_ALM_BIT]  = alm_flag_i;
            end
            RA_IEN:  rdata_o[IEN_ALM_BIT] = ien_q;
            default: rdata_o = '0;
        endcase
    end

    assign unused_wdata = ^wdata_i;
    assign ien_o        = ien_q;
    assign lock_soft_o  = soft_q;
    assign lock_hard_o  = hard_q;
    assign ovf_o        = ovf_q;

endmodule

// File: rtl/secure_rtc.sv
// Module: secure seconds counter with alarm (top).
// Joins the register block, the time base and the alarm compare. The
// interrupt is the alarm flag masked by its enable, with no extra register.
// Assumes tick_i is a single-cycle strobe synchronous to clk.
module secure_rtc #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fail_i,
    input  logic              nv_set_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    logic [SEC_W-1:0]  sec_w, alm_w;
    logic [FRAC_W-1:0] frac_w;
    logic run_w, wr_sec_w, wr_frac_w, wr_alm_w, clr_alm_w;
    logic step_w, wrap_w, alm_flag_w, ien_w;
    logic lock_soft_w, lock_hard_w, ovf_w;

    secure_rtc_regs #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .fail_i(fail_i),
        .nv_set_i(nv_set_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wrap_i(wrap_w), .alm_flag_i(alm_flag_w),
        .sec_i(sec_w), .frac_i(frac_w), .alm_i(alm_w), .run_o(run_w),
        .wr_sec_o(wr_sec_w), .wr_frac_o(wr_frac_w), .wr_alm_o(wr_alm_w),
        .clr_alm_o(clr_alm_w), .ien_o(ien_w), .lock_soft_o(lock_soft_w),
        .lock_hard_o(lock_hard_w), .ovf_o(ovf_w), .rdata_o(rdata_o)
    );

    secure_rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .wr_sec_i(wr_sec_w),
        .wr_frac_i(wr_frac_w), .sec_wdata_i(wdata_i[SEC_W-1:0]),
        .frac_wdata_i(wdata_i[FRAC_W-1:0]), .sec_o(sec_w), .frac_o(frac_w),
        .step_o(step_w), .wrap_o(wrap_w)
    );

    secure_rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .step_i(step_w), .sec_i(sec_w),
        .wr_alm_i(wr_alm_w), .alm_wdata_i(wdata_i[SEC_W-1:0]),
        .clr_i(clr_alm_w), .alm_o(alm_w), .flag_o(alm_flag_w)
    );

    // Interrupt: alarm flag gated by its enable.
    always_comb begin
        irq_o = alm_flag_w && ien_w;
    end

endmodule

// File: rtl/secure_rtc_checker.sv
// Module: temporal checks on the secure seconds counter, bound to the top.
// Observes ports and the nets between the register block, the time base
// and the alarm compare.
module secure_rtc_checker
    import secure_rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o,
    input logic              run_w,
    input logic              wr_sec_w,
    input logic              wr_frac_w,
    input logic [SEC_W-1:0]  sec_w,
    input logic [FRAC_W-1:0] frac_w,
    input logic [SEC_W-1:0]  alm_w,
    input logic              alm_flag_w,
    input logic              ien_w,
    input logic              ovf_w,
    input logic              lock_soft_w,
    input logic              lock_hard_w
);
    localparam logic [FRAC_W-1:0] FRAC_MAX = '1;

    // R1: a running cycle below the fraction maximum advances it by one.
    a_r1_frac_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !wr_frac_w && frac_w != FRAC_MAX) |=> frac_w == $past(frac_w) + 1'b1);

    // R2: without running and without a write, the fraction holds.
    a_r2_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !wr_frac_w) |=> $stable(frac_w));

    // R3: the overflow flag rises only together with seconds at zero.
    a_r3_no_overflow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_w) && !$past(wr_sec_w)) |-> sec_w == '0);

    // R5: lock bits never clear while out of reset.
    a_r5_soft_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_soft_w |=> lock_soft_w);
    a_r5_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hard_w |=> lock_hard_w);

    // R5: while locked and not counting, seconds cannot change.
    a_r5_locked_sec: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_soft_w || lock_hard_w) && !run_w) |=> $stable(sec_w));

    // R6: a newly raised alarm flag coincides with seconds equal to alarm.
    a_r6_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag_w) |-> sec_w == alm_w);

    // R7: a masked alarm never drives the interrupt.
    a_r7_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_w |-> !irq_o);

    // R8: the alarm fraction word always reads zero.
    a_r8_almf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == RA_ALMF) |-> rdata_o == '0);

endmodule

bind secure_rtc secure_rtc_checker #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .run_w(run_w), .wr_sec_w(wr_sec_w), .wr_frac_w(wr_frac_w), .sec_w(sec_w),
    .frac_w(frac_w), .alm_w(alm_w), .alm_flag_w(alm_flag_w), .ien_w(ien_w),
    .ovf_w(ovf_w), .lock_soft_w(lock_soft_w), .lock_hard_w(lock_hard_w)
);

// File: tb/secure_rtc_bench.sv
// Bench: table-driven register and tick sequence, then directed tests for
// reset, overflow, the unset alarm, halt inputs and locks.
module secure_rtc_bench;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_TK  = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;
    localparam int NVEC = 40;

    // Entry: {op[1:0], addr[2:0], data[31:0], expected[31:0], req[3:0]}
    localparam logic [72:0] VEC [NVEC] = '{
        {OP_RD,  3'd4, 32'h0,        32'h0,        4'd9}, // R9 control
        {OP_RD,  3'd2, 32'h0,        32'hFFFFFFFF, 4'd8}, // R8 alarm reset
        {OP_TK,  3'd0, 32'd5,        32'h0,        4'd2},
        {OP_RD,  3'd1, 32'h0,        32'h0,        4'd2}, // R2 enable clear
        {OP_WR,  3'd4, 32'h8,        32'h0,        4'd2},
        {OP_WR,  3'd1, 32'h7FFD,     32'h0,        4'd4},
        {OP_WR,  3'd0, 32'd10,       32'h0,        4'd4},
        {OP_RD,  3'd1, 32'h0,        32'h7FFD,     4'd4}, // R4 fraction kept
        {OP_TK,  3'd0, 32'd2,        32'h0,        4'd1},
        {OP_RD,  3'd1, 32'h0,        32'h7FFF,     4'd1}, // R1
        {OP_RD,  3'd0, 32'h0,        32'd10,       4'd1},
        {OP_TK,  3'd0, 32'd1,        32'h0,        4'd1},
        {OP_RD,  3'd1, 32'h0,        32'h0,        4'd1},
        {OP_RD,  3'd0, 32'h0,        32'd11,       4'd1}, // R1 carry
        {OP_WR,  3'd2, 32'd12,       32'h0,        4'd6},
        {OP_WR,  3'd6, 32'h10,       32'h0,        4'd7},
        {OP_WR,  3'd1, 32'h7FFF,     32'h0,        4'd6},
        {OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd7},
        {OP_TK,  3'd0, 32'd1,        32'h0,        4'd6},
        {OP_RD,  3'd0, 32'h0,        32'd12,       4'd6},
        {OP_RD,  3'd5, 32'h0,        32'h10,       4'd6}, // R6 flag set
        {OP_IRQ, 3'd0, 32'h0,        32'h1,        4'd7}, // R7
        {OP_RD,  3'd3, 32'h0,        32'h0,        4'd8}, // R8
        {OP_WR,  3'd3, 32'h1234,     32'h0,        4'd8},
        {OP_RD,  3'd3, 32'h0,        32'h0,        4'd8},
        {OP_TK,  3'd0, 32'd0,        32'h0,        4'd6},
        {OP_WR,  3'd5, 32'h10,       32'h0,        4'd6},
        {OP_RD,  3'd5, 32'h0,        32'h0,        4'd6}, // R6 clear
        {OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd7},
        {OP_TK,  3'd0, 32'd3,        32'h0,        4'd6},
        {OP_RD,  3'd5, 32'h0,        32'h0,        4'd6}, // R6 no re-set
        {OP_RD,  3'd1, 32'h0,        32'd3,       4'd1},
        {OP_WR,  3'd6, 32'h0,        32'h0,        4'd7},
        {OP_WR,  3'd2, 32'd13,       32'h0,        4'd6},
        {OP_WR,  3'd1, 32'h7FFF,     32'h0,        4'd6},
        {OP_TK,  3'd0, 32'd1,        32'h0,        4'd6},
        {OP_RD,  3'd5, 32'h0,        32'h10,       4'd6},
        {OP_IRQ, 3'd0, 32'h0,        32'h0,        4'd7}, // R7 masked
        {OP_WR,  3'd5, 32'h10,       32'h0,        4'd6},
        {OP_RD,  3'd0, 32'h0,        32'd13,       4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        fail_i = 1'b0;
    logic        nv_set_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [31:0] wdata_i = 32'h0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    secure_rtc u_secure_rtc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .fail_i(fail_i),
        .nv_set_i(nv_set_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        addr_i = a;
        #1;
        checks++;
        if (rdata_o !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata_o, exp);
        end
    endtask

    task automatic do_irq(input logic exp, input string req);
        #1;
        checks++;
        if (irq_o !== exp) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b", req, irq_o, exp);
        end
    endtask

    task automatic do_tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R9: reset state
        do_rd(3'd0, 32'h0, "R9");
        do_rd(3'd1, 32'h0, "R9");
        do_rd(3'd5, 32'h0, "R9");
        do_rd(3'd6, 32'h0, "R9");
        do_irq(1'b0, "R9");

        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[v][3:0]);
            case (VEC[v][72:71])
                OP_WR:  do_wr(VEC[v][70:68], VEC[v][67:36]);
                OP_RD:  do_rd(VEC[v][70:68], VEC[v][35:4], tag);
                OP_TK:  do_tk(int'(VEC[v][67:36]));
                default: do_irq(VEC[v][4], tag);
            endcase
        end

        // R3: overflow wraps, flags and halts until cleared
        do_wr(3'd0, 32'hFFFFFFFF);
        do_wr(3'd1, 32'h7FFF);
        do_tk(1);
        do_rd(3'd0, 32'h0, "R3");
        do_rd(3'd1, 32'h0, "R3");
        do_rd(3'd5, 32'h4, "R3");
        do_tk(3);
        do_rd(3'd1, 32'h0, "R3");
        do_wr(3'd5, 32'h4);
        do_tk(1);
        do_rd(3'd1, 32'h1, "R3");

        // R8: unset alarm still matches the last second
        do_wr(3'd2, 32'hFFFFFFFF);
        do_wr(3'd0, 32'hFFFFFFFE);
        do_wr(3'd1, 32'h7FFF);
        do_tk(1);
        do_rd(3'd0, 32'hFFFFFFFF, "R8");
        do_rd(3'd5, 32'h10, "R8");
        do_wr(3'd5, 32'h10);
        do_wr(3'd1, 32'h5);

        // R2: failure input halts counting and shows in status bit 0
        @(negedge clk); fail_i = 1'b1;
        do_rd(3'd5, 32'h1, "R2");
        do_tk(3);
        do_rd(3'd1, 32'h5, "R2");
        @(negedge clk); fail_i = 1'b0;
        do_tk(1);
        do_rd(3'd1, 32'h6, "R2");

        // R2: not-valid flag halts counting until cleared
        @(negedge clk); nv_set_i = 1'b1;
        @(negedge clk); nv_set_i = 1'b0;
        do_rd(3'd5, 32'h2, "R2");
        do_tk(2);
        do_rd(3'd1, 32'h6, "R2");
        do_wr(3'd5, 32'h2);
        do_tk(1);
        do_rd(3'd1, 32'h7, "R2");

        // R5: soft lock blocks time writes and enable changes
        do_wr(3'd4, 32'h0002_0008);
        do_wr(3'd0, 32'd55);
        do_rd(3'd0, 32'hFFFFFFFF, "R5");
        do_wr(3'd1, 32'h100);
        do_rd(3'd1, 32'h7, "R5");
        do_wr(3'd4, 32'h0);
        do_rd(3'd4, 32'h0002_0008, "R5");
        do_tk(1);
        do_rd(3'd1, 32'h8, "R5");

        // R5: hard lock after a fresh reset
        do_reset();
        do_rd(3'd4, 32'h0, "R9");
        do_wr(3'd4, 32'h0004_0008);
        do_wr(3'd0, 32'd9);
        do_rd(3'd0, 32'h0, "R5");
        do_wr(3'd4, 32'h0);
        do_rd(3'd4, 32'h0004_0008, "R5");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule